// File: doc/BRIEF.md
# Bus Frame Checker with CRC8

This block sits behind a bit-level serial-bus slave front end, which hands it one byte per strobe and marks each start and stop condition with a one-cycle pulse. It decides whether a frame is for this device, verifies the redundant address copy that every frame carries, and can also verify a trailing CRC8 byte. A write frame that passes every check is committed: a one-cycle accept pulse is raised and the payload bytes appear on a wide data output. A write frame that fails is discarded as a whole, and it raises a reject pulse and a sticky error flag. The error flag stays set until the status register is read.

The device address has seven bits. Its two upper bits are fixed at binary 11, and its five lower bits come from a programmable input. Every frame opens with the address byte (address in bits 7:1, direction in bit 0, where 1 means read). The next byte is the address again, shifted down one place so that its most significant bit is 0. The CRC uses the polynomial x^8+x^5+x^3+x^2+x+1 (0x2F). It starts from 0x00, takes data MSB first and covers every byte of the frame. For read frames the block provides the running CRC over all bytes seen so far, so the front end can append that value as the closing byte.

Top module: `frame_guard`

## Requirements
- R1: After reset, wr_accept, wr_reject, err_flag, rd_crc_valid, rd_crc and wr_data are all 0.
- R2: A frame is addressed to this device when bits 7:1 of its first byte equal {2'b11, dev_addr_lo}. Any other frame is ignored: no accept, no reject, and err_flag is left unchanged.
- R3: The second byte must equal {1'b0, address from the first byte}. If it differs, the frame is rejected.
- R4: A write frame (bit 0 of the first byte is 0) must hold exactly 2 + DATA_BYTES bytes, plus one more when crc_check_en is 1. Any other count is rejected.
- R5: When crc_check_en is 1, the last byte of a write frame must equal the CRC8 (polynomial 0x2F, initial value 0x00, MSB first, no final XOR) of all the bytes before it. If it does not, the frame is rejected.
- R6: An accepted write gives a one-cycle wr_accept pulse in the cycle after the stop marker. In the same cycle wr_data takes the payload bytes, with the first payload byte in the most significant byte.
- R7: A rejected frame gives a one-cycle wr_reject pulse in the cycle after the stop marker, and wr_data keeps its previous value.
- R8: A reject sets err_flag, and err_flag stays set. It clears in the cycle after a status_read pulse. If a reject and a status_read occur in the same cycle, err_flag stays set.
- R9: For a read frame (bit 0 of the first byte is 1), rd_crc equals the CRC8 of all bytes received so far. rd_crc_valid is 1 from the third byte on, provided crc_check_en is 1, the address matches and the repeated byte is correct. A read frame never produces wr_accept.
- R10: A start marker discards any partial frame and begins a new one. Bytes that arrive after a stop marker and before the next start marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A received or transmitted bus byte is present on byte_data |
| byte_data | input | 8 | Bus byte |
| frame_start | input | 1 | Start condition pulse |
| frame_stop | input | 1 | Stop condition pulse |
| crc_check_en | input | 1 | Enables CRC checking |
| dev_addr_lo | input | 5 | Programmable lower address bits |
| status_read | input | 1 | Status register read pulse; clears err_flag |
| wr_accept | output | 1 | Pulse: write frame committed |
| wr_reject | output | 1 | Pulse: frame rejected |
| wr_data | output | 16 | Payload of the last accepted write |
| err_flag | output | 1 | Sticky communication error |
| rd_crc | output | 8 | Running CRC of the current frame |
| rd_crc_valid | output | 1 | rd_crc may be appended to a read frame |

## Verification
A table of write frames is applied with and without CRC checking. The table holds correct frames, a frame with a corrupted CRC byte, repeated-address bytes that differ in the top bit or the bottom bit, and a frame for another address. It also holds a short frame, a long frame, and frames where the CRC byte is missing or surplus to the configuration. Together these show which single check caused each reject, and that a foreign frame is told apart from a bad one. Directed tests then cover the running CRC of a read frame, an error read that coincides with a reject, a restart in the middle of a frame, and stray bytes between frames.

// File: rtl/frame_guard_pkg.sv
package frame_guard_pkg;

   localparam logic [7:0] CRC8_POLY_DEFAULT = 8'h2F;

   typedef enum logic [1:0] {
      VERD_NONE   = 2'd0,
      VERD_ACCEPT = 2'd1,
      VERD_REJECT = 2'd2
   } verdict_e;

   // One byte folded into the CRC, most significant bit first.
   function automatic logic [7:0] crc8_step(input logic [7:0] c_in,
                                            input logic [7:0] b,
                                            input logic [7:0] poly);
      logic [7:0] c;
      logic       fb;
      c = c_in;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ b[i];
         c  = {c[6:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction

endpackage

// File: rtl/fg_crc8.sv
module fg_crc8 #(
   parameter logic [7:0] POLY = frame_guard_pkg::CRC8_POLY_DEFAULT
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [7:0] din,
   output logic [7:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= 8'h00;
      else if (clr) crc <= 8'h00;
      else if (en)  crc <= frame_guard_pkg::crc8_step(crc, din, POLY);
   end

   // R9: a cleared register reads zero
   assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (crc == 8'h00));
endmodule

// File: rtl/fg_addr_cmp.sv
module fg_addr_cmp #(
   parameter int ADDR_W = 7,
   parameter int PROG_W = 5,
   parameter logic [ADDR_W-PROG_W-1:0] FIXED_HI = '1
) (
   input  logic [PROG_W-1:0] prog_lo,
   input  logic [7:0]        byte_in,
   input  logic [ADDR_W-1:0] first_addr,
   output logic              head_match,
   output logic              dup_match
);
   logic [ADDR_W-1:0] dev_addr;
   assign dev_addr   = {FIXED_HI, prog_lo};
   assign head_match = (byte_in[7:1] == dev_addr);
   assign dup_match  = (byte_in == {1'b0, first_addr});
endmodule

// File: rtl/fg_payload.sv
module fg_payload #(
   parameter int DATA_BYTES = 2,
   parameter int CNT_W      = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap,
   input  logic [CNT_W-1:0]        idx,
   input  logic [7:0]              din,
   input  logic                    commit,
   output logic [DATA_BYTES*8-1:0] data_out
);
   logic [DATA_BYTES*8-1:0] staged;

   for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
      logic [7:0] lane;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane <= 8'h00;
         else if (cap && (idx == CNT_W'(2 + g))) lane <= din;
      end
      assign staged[(DATA_BYTES-1-g)*8 +: 8] = lane;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_out <= '0;
      else if (commit) data_out <= staged;
   end

   // R7: the committed payload only moves on a commit
   assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_out) |-> $past(commit));
endmodule

// File: rtl/frame_guard.sv
module frame_guard #(
   parameter int DATA_BYTES = 2,
   parameter int ADDR_W     = 7,
   parameter int PROG_W     = 5,
   parameter logic [ADDR_W-PROG_W-1:0] FIXED_HI = '1,
   parameter logic [7:0] POLY = frame_guard_pkg::CRC8_POLY_DEFAULT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_valid,
   input  logic [7:0]              byte_data,
   input  logic                    frame_start,
   input  logic                    frame_stop,
   input  logic                    crc_check_en,
   input  logic [PROG_W-1:0]       dev_addr_lo,
   input  logic                    status_read,
   output logic                    wr_accept,
   output logic                    wr_reject,
   output logic [DATA_BYTES*8-1:0] wr_data,
   output logic                    err_flag,
   output logic [7:0]              rd_crc,
   output logic                    rd_crc_valid
);
   import frame_guard_pkg::*;

   localparam int BASE_LEN = 2 + DATA_BYTES;
   localparam int LEN_MAX  = BASE_LEN + 2;
   localparam int CNT_W    = $clog2(LEN_MAX + 1);

   if (ADDR_W != 7)                  $error("frame_guard: ADDR_W must be 7");
   if (PROG_W < 1 || PROG_W >= ADDR_W) $error("frame_guard: PROG_W out of range");
   if (DATA_BYTES < 1)               $error("frame_guard: DATA_BYTES must be >= 1");

   logic              in_frame, is_read, foreign, dup_bad;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] first_addr;
   logic              take, head_match, dup_match;
   logic [7:0]        crc;
   logic [CNT_W-1:0]  exp_len;
   verdict_e          verd;

   assign take    = byte_valid && in_frame && !frame_start;
   assign exp_len = crc_check_en ? CNT_W'(BASE_LEN + 1) : CNT_W'(BASE_LEN);

   fg_crc8 #(.POLY(POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(frame_start), .en(take),
      .din(byte_data), .crc(crc));

   fg_addr_cmp #(.ADDR_W(ADDR_W), .PROG_W(PROG_W), .FIXED_HI(FIXED_HI)) u_cmp (
      .prog_lo(dev_addr_lo), .byte_in(byte_data), .first_addr(first_addr),
      .head_match(head_match), .dup_match(dup_match));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame   <= 1'b0;
         cnt        <= '0;
         is_read    <= 1'b0;
         foreign    <= 1'b0;
         dup_bad    <= 1'b0;
         first_addr <= '0;
      end else if (frame_start) begin
         in_frame <= 1'b1;
         cnt      <= '0;
         is_read  <= 1'b0;
         foreign  <= 1'b0;
         dup_bad  <= 1'b0;
      end else if (frame_stop) begin
         in_frame <= 1'b0;
      end else if (take) begin
         if (cnt != CNT_W'(LEN_MAX)) cnt <= cnt + 1'b1;
         if (cnt == '0) begin
            first_addr <= byte_data[7:1];
            is_read    <= byte_data[0];
            foreign    <= !head_match;
         end
         if (cnt == CNT_W'(1)) dup_bad <= !dup_match;
      end
   end

   always_comb begin
      verd = VERD_NONE;
      if (frame_stop && in_frame && !frame_start && cnt != '0 && !foreign) begin
         if (cnt < CNT_W'(2) || dup_bad)                verd = VERD_REJECT;
         else if (is_read)                              verd = VERD_NONE;
         else if (cnt != exp_len)                       verd = VERD_REJECT;
         else if (crc_check_en && crc != 8'h00)         verd = VERD_REJECT;
         else                                           verd = VERD_ACCEPT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_accept <= 1'b0;
         wr_reject <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         wr_accept <= (verd == VERD_ACCEPT);
         wr_reject <= (verd == VERD_REJECT);
         if (verd == VERD_REJECT) err_flag <= 1'b1;
         else if (status_read)    err_flag <= 1'b0;
      end
   end

   fg_payload #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)) u_pay (
      .clk(clk), .rst_n(rst_n), .cap(take && !is_read), .idx(cnt),
      .din(byte_data), .commit(verd == VERD_ACCEPT), .data_out(wr_data));

   assign rd_crc       = crc;
   assign rd_crc_valid = in_frame && is_read && !foreign && !dup_bad &&
                         (cnt >= CNT_W'(2)) && crc_check_en;

   // R6: accept follows a stop marker
   assert_accept_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |-> $past(frame_stop));
   // R7: accept and reject never together
   assert_verdict_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_accept && wr_reject));
   // R8: error only rises with a reject
   assert_err_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> wr_reject);
   // R8: error only clears after a status read
   assert_err_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag) |-> $past(status_read));
   // R9: read frames never commit
   assert_read_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stop && in_frame && is_read) |=> !wr_accept);
endmodule

// File: tb/frame_guard_tb.sv
module frame_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic        frame_start = 1'b0, frame_stop = 1'b0;
   logic        crc_check_en = 1'b0;
   logic [4:0]  dev_addr_lo = 5'h05;
   logic        status_read = 1'b0;
   logic        wr_accept, wr_reject, err_flag, rd_crc_valid;
   logic [15:0] wr_data;
   logic [7:0]  rd_crc;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   frame_guard u_dut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .frame_start(frame_start), .frame_stop(frame_stop),
      .crc_check_en(crc_check_en), .dev_addr_lo(dev_addr_lo),
      .status_read(status_read), .wr_accept(wr_accept), .wr_reject(wr_reject),
      .wr_data(wr_data), .err_flag(err_flag), .rd_crc(rd_crc),
      .rd_crc_valid(rd_crc_valid));

   function automatic logic [7:0] ref_crc(input logic [7:0] c_in, input logic [7:0] b);
      logic [7:0] c = c_in;
      for (int i = 7; i >= 0; i--) begin
         if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ 8'h2F;
         else             c = {c[6:0], 1'b0};
      end
      return c;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] b);
      byte_valid = 1'b1; byte_data = b;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask
   task automatic pulse_start();
      frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
   endtask
   task automatic pulse_stop();
      frame_stop = 1'b1; @(negedge clk); frame_stop = 1'b0;
   endtask
   task automatic clear_err();
      status_read = 1'b1; @(negedge clk); status_read = 1'b0;
   endtask

   // a: address, rw, dupx: XOR on repeated byte, nd: data bytes sent,
   // d: payload, ce: crc enable, addc: append crc, cx: XOR on crc, ex: 0 none 1 accept 2 reject
   typedef struct packed {
      logic [6:0]  a;
      logic        rw;
      logic [7:0]  dupx;
      logic [2:0]  nd;
      logic [15:0] d;
      logic        ce;
      logic        addc;
      logic [7:0]  cx;
      logic [1:0]  ex;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{7'h65, 1'b0, 8'h00, 3'd2, 16'hCFFF, 1'b0, 1'b0, 8'h00, 2'd1}, // R6 plain write
      '{7'h65, 1'b0, 8'h00, 3'd2, 16'h1234, 1'b1, 1'b1, 8'h00, 2'd1}, // R5 good crc
      '{7'h65, 1'b0, 8'h00, 3'd2, 16'hABCD, 1'b1, 1'b1, 8'h01, 2'd2}, // R5 bad crc
      '{7'h65, 1'b0, 8'h80, 3'd2, 16'h1111, 1'b0, 1'b0, 8'h00, 2'd2}, // R3 msb set
      '{7'h45, 1'b0, 8'h00, 3'd2, 16'h2222, 1'b0, 1'b0, 8'h00, 2'd0}, // R2 foreign
      '{7'h65, 1'b0, 8'h00, 3'd1, 16'h3333, 1'b0, 1'b0, 8'h00, 2'd2}, // R4 short
      '{7'h65, 1'b0, 8'h00, 3'd3, 16'h4444, 1'b0, 1'b0, 8'h00, 2'd2}, // R4 long
      '{7'h65, 1'b0, 8'h00, 3'd2, 16'h5555, 1'b1, 1'b0, 8'h00, 2'd2}, // R4 crc missing
      '{7'h65, 1'b0, 8'h00, 3'd2, 16'h6666, 1'b0, 1'b1, 8'h00, 2'd2}, // R4 surplus crc
      '{7'h65, 1'b0, 8'h01, 3'd2, 16'h7777, 1'b1, 1'b1, 8'h00, 2'd2}  // R3 lsb wrong
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] last_data;
      logic [7:0]  c;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 accept", wr_accept, 0);
      check("R1 reject", wr_reject, 0);
      check("R1 err", err_flag, 0);
      check("R1 rd_crc", {rd_crc_valid, rd_crc}, 0);
      check("R1 data", wr_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      last_data = 16'h0000;

      foreach (VECS[k]) begin
         vec_t v;
         v = VECS[k];
         crc_check_en = v.ce;
         clear_err();
         pulse_start();
         c = 8'h00;
         put_byte({v.a, v.rw});         c = ref_crc(c, {v.a, v.rw});
         put_byte({1'b0, v.a} ^ v.dupx); c = ref_crc(c, {1'b0, v.a} ^ v.dupx);
         for (int j = 0; j < int'(v.nd); j++) begin
            logic [7:0] b;
            b = (j == 0) ? v.d[15:8] : (j == 1) ? v.d[7:0] : 8'h5A;
            put_byte(b); c = ref_crc(c, b);
         end
         if (v.addc) put_byte(c ^ v.cx);
         pulse_stop();
         if (v.ex == 2'd1) last_data = v.d;
         check($sformatf("R6 accept vec%0d", k), wr_accept, v.ex == 2'd1);
         check($sformatf("R7 reject vec%0d", k), wr_reject, v.ex == 2'd2);
         check($sformatf("R7 data vec%0d", k), wr_data, last_data);
         check($sformatf("R8 err vec%0d", k), err_flag, v.ex == 2'd2);
         @(negedge clk);
         check($sformatf("R6 pulse width vec%0d", k), {wr_accept, wr_reject}, 0);
      end

      // R8 sticky, then cleared by status read
      check("R8 sticky", err_flag, 1);
      clear_err();
      check("R8 cleared", err_flag, 0);

      // R8 reject coinciding with status read keeps the flag
      crc_check_en = 1'b0;
      pulse_start();
      put_byte(8'hCA); put_byte(8'hE5); put_byte(8'h01); put_byte(8'h02);
      frame_stop = 1'b1; status_read = 1'b1;
      @(negedge clk);
      frame_stop = 1'b0; status_read = 1'b0;
      check("R8 set wins", err_flag, 1);
      clear_err();

      // R9 read frame running crc
      crc_check_en = 1'b1;
      pulse_start();
      c = 8'h00;
      put_byte(8'hCB); c = ref_crc(c, 8'hCB);
      check("R9 valid low after one byte", rd_crc_valid, 0);
      put_byte(8'h65); c = ref_crc(c, 8'h65);
      put_byte(8'h3C); c = ref_crc(c, 8'h3C);
      put_byte(8'hA7); c = ref_crc(c, 8'hA7);
      check("R9 valid", rd_crc_valid, 1);
      check("R9 crc", rd_crc, c);
      pulse_stop();
      check("R9 no accept", {wr_accept, wr_reject, err_flag}, 0);

      // R10 restart mid-frame
      crc_check_en = 1'b0;
      pulse_start();
      put_byte(8'hCA); put_byte(8'h99);
      pulse_start();
      put_byte(8'hCA); put_byte(8'h65); put_byte(8'hBE); put_byte(8'hEF);
      pulse_stop();
      check("R10 restart accept", wr_accept, 1);
      check("R10 restart data", wr_data, 16'hBEEF);

      // R10 stray bytes between frames
      put_byte(8'hCA); put_byte(8'h65); put_byte(8'h00); put_byte(8'h00);
      pulse_stop();
      check("R10 stray ignored", {wr_accept, wr_reject, err_flag}, 0);
      check("R10 stray data", wr_data, 16'hBEEF);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule